// File: doc/BRIEF.md
# Scanline Interrupt Counter with Selectable Edge Variant

This block counts video scanlines for a cartridge bank-switching controller and pulls an active-low interrupt line low when its count runs out. It watches the graphics address line A12, which toggles once per scanline during normal rendering. A qualified A12 transition clocks a down-counter that reloads itself from a CPU-written latch. The CPU programs the block through four write-only registers: latch value, reload request, disable with acknowledge, and enable.

A static two-bit variant input picks one of three silicon behaviours from a single counter. Two variants count on the low-to-high A12 transition. They differ only in how a zero count reached by reloading is treated. The third variant counts on the high-to-low transition, and its counter clock is delayed by a fixed number of CPU cycles. A board jumper input forces the interrupt line off no matter what the registers hold. A12 transitions are filtered, so the short toggles seen during sprite fetches do not count.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset the interrupt output `irq_n` is high, the counter and the latch hold 0, no reload is pending and interrupts are disabled.
- R2: Variant codes on `variant_sel` are 0 (old rising), 1 (new rising), 2 (falling, delayed) and 3 (treated as 1). In variants 0, 1 and 3 a qualified low-to-high A12 transition clocks the counter. In variant 2 a qualified high-to-low transition clocks it.
- R3: On each counter clock, the counter loads the latch value and clears the pending reload if it holds 0 or a reload is pending. Otherwise it decrements by one.
- R4: In variant 0 an interrupt is raised only when a counter clock brings the counter from 1 to 0. A latch value of 0 therefore never interrupts.
- R5: In variants 1, 2 and 3 an interrupt is raised whenever the counter is 0 after a counter clock, including a reload of 0. A latch of 0 then interrupts on every scanline. An interrupt requires enable to be set and the jumper to be clear.
- R6: An A12 transition counts only if A12 held its previous level for at least `FILT_CYC` clock cycles (default 3). Shorter excursions are ignored.
- R7: In variant 2 the interrupt arrives exactly `FALL_DLY` clock cycles (default 2) later after its A12 transition than a variant 1 interrupt does after its own transition.
- R8: A disable write drives `irq_n` high on the next clock and keeps it high until an enable write follows.
- R9: While `irq_jumper_off` is high, `irq_n` is high from the next clock on, and no interrupt is recorded.
- R10: A write with `wr_en` high is decoded from `cpu_a_top` (address bits 15..13) and `cpu_a0`. 3'b110 with A0=0 writes the latch from `cpu_data`. 3'b110 with A0=1 requests a reload. 3'b111 with A0=0 is disable. 3'b111 with A0=1 is enable. Every other address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| variant_sel | input | 2 | Static behaviour select (see R2) |
| wr_en | input | 1 | CPU register write strobe, one cycle per write |
| cpu_a_top | input | 3 | CPU address bits 15..13 |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_data | input | DATA_W | CPU write data |
| ppu_a12 | input | 1 | Graphics address line A12 |
| irq_jumper_off | input | 1 | Board jumper, high forces interrupts off |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit counter, a 3-cycle edge filter and a 2-cycle falling-edge delay. Latch values are drawn from 0 to 3, so the zero-reload, reload-pending and decrement-to-zero paths recur many times per variant within a few dozen scanlines. Because the filter is only 3 cycles long, glitches of 2 and 3 cycles sit right on its boundary. Because the delay is 2 cycles, the latency difference between the falling and rising variants is a small, exact number the bench can compare.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  typedef enum logic [1:0] {
    VAR_OLD_RISE = 2'd0,
    VAR_NEW_RISE = 2'd1,
    VAR_FALL_DLY = 2'd2,
    VAR_NEW_ALT  = 2'd3
  } variant_e;

  typedef enum logic [1:0] {
    REG_LATCH   = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_DISABLE = 2'd2,
    REG_ENABLE  = 2'd3
  } reg_sel_e;

  localparam logic [2:0] GRP_COUNT = 3'b110;
  localparam logic [2:0] GRP_IRQ   = 3'b111;

endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int FILT_CYC = 3,
  parameter int FALL_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12_in,
  input  logic use_fall,
  output logic tick_o
);
  localparam int RW = $clog2(FILT_CYC + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(FILT_CYC);

  logic          a12_q, a12_d;
  logic [RW-1:0] run_q, run_d;
  logic          rise_q, rise_d;
  logic          fall_q, fall_d;
  logic          fall_late;
  logic          changed, long_enough;

  always_comb begin
    changed     = a12_in != a12_q;
    long_enough = run_q >= RUN_FULL;
    a12_d       = a12_in;
    rise_d      = changed &  a12_in & long_enough;
    fall_d      = changed & ~a12_in & long_enough;
    if (changed)          run_d = RW'(1);
    else if (long_enough) run_d = run_q;
    else                  run_d = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a12_q  <= 1'b0;
      run_q  <= RUN_FULL;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      a12_q  <= a12_d;
      run_q  <= run_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  generate
    if (FALL_DLY == 0) begin : g_no_delay
      assign fall_late = fall_q;
    end else begin : g_delay
      logic [FALL_DLY-1:0] dly_q, dly_d;
      always_comb begin
        dly_d[0] = fall_q;
        for (int i = 1; i < FALL_DLY; i++) dly_d[i] = dly_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
      end
      assign fall_late = dly_q[FALL_DLY-1];
    end
  endgenerate

  assign tick_o = use_fall ? fall_late : rise_q;

  // R6: a qualified edge needs a settled level, so ticks never come back to back
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] latch_val,
  input  logic             reload_wr,
  input  logic             old_mode,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             hit_q, hit_d;
  logic             from_reload;

  always_comb begin
    cnt_d       = cnt_q;
    pend_d      = pend_q;
    from_reload = 1'b0;
    if (tick) begin
      if (cnt_q == '0 || pend_q) begin
        cnt_d       = latch_val;
        pend_d      = 1'b0;
        from_reload = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (reload_wr) pend_d = 1'b1;
    hit_d = tick && (cnt_d == '0) && !(old_mode && from_reload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      hit_q  <= hit_d;
    end
  end

  assign hit_o = hit_q;

  // R3: a hit is only reported while the counter sits at zero
  assert_hit_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> cnt_q == '0);

  // R4: in the old variant a hit always comes from a decrement out of 1
  assert_old_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (old_mode && hit_q) |-> $past(cnt_q) == CNT_W'(1));

endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic dis_wr,
  input  logic en_wr,
  input  logic jumper_off,
  output logic irq_n
);
  logic en_q, en_d;
  logic irq_n_q, irq_n_d;

  always_comb begin
    en_d = en_q;
    if (dis_wr)     en_d = 1'b0;
    else if (en_wr) en_d = 1'b1;

    irq_n_d = irq_n_q;
    if (hit && en_q && !jumper_off) irq_n_d = 1'b0;
    if (dis_wr || jumper_off)        irq_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      en_q    <= en_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n = irq_n_q;

  // R8: a disable write releases the line on the next clock
  assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> irq_n);

  // R8: with interrupts disabled the line stays released
  assert_off_stays_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> irq_n);

  // R9: the jumper forces the line high from the next clock
  assert_jumper_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jumper_off |=> irq_n);

  // R5: the line only falls after a counter hit
  assert_fall_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(hit));

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit #(
  parameter int DATA_W   = 8,
  parameter int FILT_CYC = 3,
  parameter int FALL_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        variant_sel,
  input  logic              wr_en,
  input  logic [2:0]        cpu_a_top,
  input  logic              cpu_a0,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              ppu_a12,
  input  logic              irq_jumper_off,
  output logic              irq_n
);
  import scan_irq_pkg::*;

  logic              rst_meta_q, rst_sync_q;
  logic              wr_latch, wr_reload, wr_dis, wr_en_irq;
  logic [DATA_W-1:0] latch_q, latch_d;
  logic              old_mode, fall_mode;
  logic              tick, hit;
  variant_e          variant;
  reg_sel_e          sel;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    variant   = variant_e'(variant_sel);
    old_mode  = variant == VAR_OLD_RISE;
    fall_mode = variant == VAR_FALL_DLY;

    sel       = reg_sel_e'({cpu_a_top[0], cpu_a0});
    wr_latch  = 1'b0;
    wr_reload = 1'b0;
    wr_dis    = 1'b0;
    wr_en_irq = 1'b0;
    if (wr_en && (cpu_a_top == GRP_COUNT || cpu_a_top == GRP_IRQ)) begin
      unique case (sel)
        REG_LATCH:   wr_latch  = 1'b1;
        REG_RELOAD:  wr_reload = 1'b1;
        REG_DISABLE: wr_dis    = 1'b1;
        REG_ENABLE:  wr_en_irq = 1'b1;
        default:     ;
      endcase
    end

    latch_d = wr_latch ? cpu_data : latch_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) latch_q <= '0;
    else             latch_q <= latch_d;
  end

  a12_edge_filter #(
    .FILT_CYC (FILT_CYC),
    .FALL_DLY (FALL_DLY)
  ) i_filter (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .a12_in   (ppu_a12),
    .use_fall (fall_mode),
    .tick_o   (tick)
  );

  scan_counter #(
    .CNT_W (DATA_W)
  ) i_counter (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .tick      (tick),
    .latch_val (latch_q),
    .reload_wr (wr_reload),
    .old_mode  (old_mode),
    .hit_o     (hit)
  );

  irq_gate i_gate (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .hit        (hit),
    .dis_wr     (wr_dis),
    .en_wr      (wr_en_irq),
    .jumper_off (irq_jumper_off),
    .irq_n      (irq_n)
  );

  // R10: register strobes are mutually exclusive
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({wr_latch, wr_reload, wr_dis, wr_en_irq}));

endmodule

// File: tb/test_scanline_irq_unit.sv
`timescale 1ns/1ps
module test_scanline_irq_unit;
  localparam int DATA_W   = 8;
  localparam int FALL_DLY = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        variant_sel;
  logic              wr_en;
  logic [2:0]        cpu_a_top;
  logic              cpu_a0;
  logic [DATA_W-1:0] cpu_data;
  logic              ppu_a12;
  logic              irq_jumper_off;
  logic              irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model state
  int  m_cnt, m_latch;
  bit  m_pend, m_en, m_irq, m_jump;
  int  m_var;

  always #2 clk = ~clk;

  scanline_irq_unit #(.DATA_W(DATA_W), .FILT_CYC(3), .FALL_DLY(FALL_DLY)) i_scanline_irq_unit (
    .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .wr_en(wr_en),
    .cpu_a_top(cpu_a_top), .cpu_a0(cpu_a0), .cpu_data(cpu_data),
    .ppu_a12(ppu_a12), .irq_jumper_off(irq_jumper_off), .irq_n(irq_n));

  function automatic bit exp_line(input bit irq);
    return !irq;
  endfunction

  task automatic chk(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: irq_n got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic model_tick();
    bit reloaded;
    if (m_cnt == 0 || m_pend) begin
      m_cnt = m_latch; m_pend = 0; reloaded = 1;
    end else begin
      m_cnt = m_cnt - 1; reloaded = 0;
    end
    if (m_cnt == 0 && m_en && !m_jump && !(m_var == 0 && reloaded)) m_irq = 1;
  endtask

  task automatic do_reset(input int v);
    @(negedge clk);
    rst_n = 0; variant_sel = 2'(v); wr_en = 0; cpu_a_top = 0; cpu_a0 = 0;
    cpu_data = 0; ppu_a12 = 0; irq_jumper_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    m_cnt = 0; m_latch = 0; m_pend = 0; m_en = 0; m_irq = 0; m_jump = 0;
    m_var = v;
    chk(irq_n, 1'b1, "R1 reset state");
  endtask

  task automatic cpu_write(input logic [2:0] top, input logic a0, input int data);
    @(negedge clk);
    wr_en = 1; cpu_a_top = top; cpu_a0 = a0; cpu_data = DATA_W'(data);
    @(negedge clk);
    wr_en = 0;
    if (wr_en == 0 && top == 3'b110 && a0 == 0) m_latch = data;
    if (top == 3'b110 && a0 == 1) m_pend = 1;
    if (top == 3'b111 && a0 == 0) begin m_en = 0; m_irq = 0; end
    if (top == 3'b111 && a0 == 1) m_en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic scan_line();
    @(negedge clk);
    ppu_a12 = 1;
    repeat (6) @(negedge clk);
    ppu_a12 = 0;
    repeat (8) @(negedge clk);
    model_tick();
    chk(irq_n, exp_line(m_irq), "R2/R3/R4/R5 scanline count");
  endtask

  task automatic hold_a12(input logic lvl, input int cyc);
    @(negedge clk);
    ppu_a12 = lvl;
    repeat (cyc - 1) @(negedge clk);
  endtask

  task automatic measure(input logic lvl, output int lat);
    @(negedge clk);
    ppu_a12 = lvl;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (irq_n == 1'b0) break;
    end
  endtask

  task automatic random_run(input int v, input int lines);
    do_reset(v);
    cpu_write(3'b110, 0, 1);
    cpu_write(3'b111, 1, 0);
    for (int n = 0; n < lines; n++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: cpu_write(3'b110, 0, $urandom % 4);
        1: cpu_write(3'b110, 1, $urandom);
        2: begin cpu_write(3'b111, 0, 0);
                 chk(irq_n, 1'b1, "R8 disable releases"); end
        3: cpu_write(3'b111, 1, 0);
        4: begin
             @(negedge clk);
             irq_jumper_off = ~irq_jumper_off; m_jump = irq_jumper_off;
             if (m_jump) m_irq = 0;
             repeat (2) @(negedge clk);
             chk(irq_n, exp_line(m_irq), "R9 jumper");
           end
        5: begin cpu_write(3'b101, $urandom % 2, $urandom);
                 chk(irq_n, exp_line(m_irq), "R10 other address ignored"); end
        default: ;
      endcase
      scan_line();
    end
    @(negedge clk);
    irq_jumper_off = 0; m_jump = 0;
  endtask

  initial begin
    int lat_rise, lat_fall;
    void'($urandom(32'd20240611));

    // directed: filter boundary in the new rising variant
    do_reset(1);
    cpu_write(3'b110, 0, 0);
    cpu_write(3'b111, 1, 0);
    cpu_write(3'b110, 1, 0);
    hold_a12(1, 8);
    chk(irq_n, 1'b0, "R5 zero latch interrupts");
    cpu_write(3'b111, 0, 0);
    chk(irq_n, 1'b1, "R8 disable clears");
    hold_a12(0, 8); hold_a12(1, 8);
    chk(irq_n, 1'b1, "R8 stays high until enable");
    cpu_write(3'b111, 1, 0);
    hold_a12(0, 2); hold_a12(1, 8);
    chk(irq_n, 1'b1, "R6 two-cycle glitch ignored");
    hold_a12(0, 3); hold_a12(1, 8);
    chk(irq_n, 1'b0, "R6 three-cycle level counts");

    // directed: jumper blocks a due interrupt
    @(negedge clk); irq_jumper_off = 1;
    @(negedge clk); @(negedge clk);
    chk(irq_n, 1'b1, "R9 jumper forces high");
    hold_a12(0, 8); hold_a12(1, 8);
    chk(irq_n, 1'b1, "R9 no interrupt while jumper set");
    @(negedge clk); irq_jumper_off = 0;

    // directed: latency comparison between rising and falling variants
    do_reset(1);
    cpu_write(3'b110, 0, 0);
    cpu_write(3'b111, 1, 0);
    measure(1, lat_rise);
    do_reset(2);
    cpu_write(3'b110, 0, 0);
    cpu_write(3'b111, 1, 0);
    hold_a12(1, 8);
    cpu_write(3'b111, 0, 0);
    cpu_write(3'b111, 1, 0);
    measure(0, lat_fall);
    checks++;
    if (lat_fall != lat_rise + FALL_DLY) begin
      errors++;
      $display("FAIL R7: fall latency got %0d expected %0d", lat_fall, lat_rise + FALL_DLY);
    end

    // directed: old variant with zero latch never interrupts (R4)
    do_reset(0);
    cpu_write(3'b110, 0, 0);
    cpu_write(3'b111, 1, 0);
    for (int k = 0; k < 4; k++) scan_line();
    chk(irq_n, 1'b1, "R4 old variant zero latch silent");

    // random runs, each variant code
    random_run(0, 60);
    random_run(1, 60);
    random_run(2, 60);
    random_run(3, 40);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule